// File: doc/BRIEF.md
# Linear Switching Surface Controller

This block decides, once per sample, whether the high-side switch of a synchronous buck converter should be on while the converter recovers from a large load step. It forms a signed switching function from two inputs. The first is the quantized output-voltage error, which is the output minus the reference. The second is an estimate of the capacitor current. The estimate is weighted by a slope, and that slope is a run-time fixed-point multiple of a base value. The supervisor picks the multiple to suit the size of the load step. The switch is turned on while the function is negative.

An optional current-limit mode protects the inductor. When the capacitor current reaches a programmed ceiling, the block holds the switch off. It keeps holding until the current falls below a lower threshold, and that band bounds the switching rate. Once the ceiling has been reached, the final turn-off is governed by a second, saturated surface with its own slope through the origin. That slope stays in force until the mode or the block is disabled. The clock of the block runs at the sample rate, which is a fixed multiple of the PWM frequency. Every clock is one sample.

Top module: `ssc_controller`

## Requirements
- R1: The switching function is S = e + (gamma/8)·(base/16)·ic. The output is 1 when S < 0 and 0 when S >= 0, so S = 0 gives 0. The signs of e, ic and base are respected, and a negative base slope is allowed.
- R2: gammaIn is unsigned with 3 fractional bits and covers 0 to 3.875 in steps of 0.125. A value of 0 reduces S to the error alone.
- R3: S is computed exactly, with no overflow, for every combination of the extreme input values.
- R4: The output is registered. A sample presented before a rising edge shows at hsOn after that edge. Before that edge hsOn keeps the previous result.
- R5: While enable is low, hsOn is 0 after the next edge. That same edge also clears both the limit-hold state and the saturated-surface state.
- R6: With limitEn high, a sample with ic >= icMax drives hsOn to 0 after that edge. This holds even when the surface alone would turn the switch on.
- R7: Once the hold is set, it stays set while ic >= icMax - icHyst and keeps hsOn at 0. The first sample with ic < icMax - icHyst releases it, and that sample is already judged against the surface.
- R8: After a limit hit, S uses satSlope (signed, 4 fractional bits) in place of the scaled slope: S = e + (sat/16)·ic. This lasts until enable or limitEn goes low.
- R9: While limitEn is low, icMax has no effect. The linear surface alone sets hsOn, and the saturated-surface state is cleared.
- R10: During reset hsOn is 0 and all limit state is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block active; low forces switch off and clears state |
| limitEn | input | 1 | Current-limit mode select |
| errIn | input | 10 | Signed output-voltage error sample |
| icIn | input | 12 | Signed capacitor-current estimate |
| baseSlope | input | 12 | Signed base slope, 4 fractional bits |
| gammaIn | input | 5 | Unsigned slope scale, 3 fractional bits |
| satSlope | input | 12 | Signed saturated-surface slope, 4 fractional bits |
| icMax | input | 12 | Signed capacitor-current ceiling |
| icHyst | input | 12 | Unsigned hysteresis depth below the ceiling |
| hsOn | output | 1 | High-side switch command |

## Verification
Two functions can act on the same sample. The current-limit detection and the surface decision both fall on the sample where ic first reaches icMax. The bench provokes this with a large negative error, so that the surface alone would turn the switch on, and expects the limit to win. The release sample is the other meeting point: the hold drops and the saturated surface takes over in the same cycle. The bench picks e and ic there so that the linear and saturated surfaces give opposite answers, which shows which of the two was used.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // Control -> datapath strobes
  typedef struct packed {
    logic useSat;   // evaluate the saturated surface instead of the linear one
  } ctrlStrobeT;

  // Datapath -> control comparison results
  typedef struct packed {
    logic surfNeg;  // selected surface value is negative
    logic atLimit;  // ic >= ceiling
    logic aboveLow; // ic >= ceiling - hysteresis
  } cmpFlagsT;

endpackage

// File: rtl/ssc_datapath.sv
module ssc_datapath
  import ssc_pkg::*;
#(
  parameter int ERR_W      = 10,
  parameter int IC_W       = 12,
  parameter int SLOPE_W    = 12,
  parameter int SLOPE_FRAC = 4,
  parameter int GAMMA_W    = 5,
  parameter int GAMMA_FRAC = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic signed [ERR_W-1:0]   errIn,
  input  logic signed [IC_W-1:0]    icIn,
  input  logic signed [SLOPE_W-1:0] baseSlope,
  input  logic        [GAMMA_W-1:0] gammaIn,
  input  logic signed [SLOPE_W-1:0] satSlope,
  input  logic signed [IC_W-1:0]    icMax,
  input  logic        [IC_W-1:0]    icHyst,
  input  ctrlStrobeT                strobe,
  output cmpFlagsT                  flags
);

  localparam int SCALE_W = GAMMA_W + 1 + SLOPE_W;       // gamma * base
  localparam int LIN_W   = SCALE_W + IC_W;              // gamma * base * ic
  localparam int SAT_W   = SLOPE_W + IC_W;              // sat * ic
  localparam int ACC_W   = LIN_W + 2;                   // sum headroom
  localparam int E_SHIFT = SLOPE_FRAC + GAMMA_FRAC;     // align error to product LSB
  localparam int THR_W   = IC_W + 2;

  logic signed [GAMMA_W:0]   gammaS;
  logic signed [SCALE_W-1:0] slopeScaled;
  logic signed [LIN_W-1:0]   linProd;
  logic signed [SAT_W-1:0]   satProd;
  logic signed [ACC_W-1:0]   errExt;
  logic signed [ACC_W-1:0]   linExt;
  logic signed [ACC_W-1:0]   satExt;
  logic signed [ACC_W-1:0]   linSum;
  logic signed [ACC_W-1:0]   satSum;
  logic signed [THR_W-1:0]   icExt;
  logic signed [THR_W-1:0]   lowThr;

  always_comb begin
    gammaS      = $signed({1'b0, gammaIn});
    slopeScaled = gammaS * baseSlope;
    linProd     = slopeScaled * icIn;
    satProd     = satSlope * icIn;
    errExt      = {{(ACC_W-ERR_W){errIn[ERR_W-1]}}, errIn} <<< E_SHIFT;
    linExt      = {{(ACC_W-LIN_W){linProd[LIN_W-1]}}, linProd};
    satExt      = {{(ACC_W-SAT_W){satProd[SAT_W-1]}}, satProd} <<< GAMMA_FRAC;
    linSum      = errExt + linExt;
    satSum      = errExt + satExt;
  end

  always_comb begin
    icExt  = {{(THR_W-IC_W){icIn[IC_W-1]}}, icIn};
    lowThr = {{(THR_W-IC_W){icMax[IC_W-1]}}, icMax} - $signed({2'b00, icHyst});
  end

  always_comb begin
    flags.surfNeg  = strobe.useSat ? satSum[ACC_W-1] : linSum[ACC_W-1];
    flags.atLimit  = (icIn >= icMax);
    flags.aboveLow = (icExt >= lowThr);
  end

  // The lower threshold never sits above the ceiling, so a hit is always inside the band
  assert_band_contains_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    flags.atLimit |-> flags.aboveLow);

  // With zero error and zero current both surfaces are exactly zero: never negative
  assert_zero_point_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    (errIn == '0 && icIn == '0) |-> !flags.surfNeg);

endmodule

// File: rtl/ssc_control.sv
module ssc_control
  import ssc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       limitEn,
  input  cmpFlagsT   flags,
  output ctrlStrobeT strobe,
  output logic       hsOn
);

  logic limHold, satMode;
  logic hitNow, holdNext, satNext, onNext;

  always_comb begin
    hitNow        = limitEn & flags.atLimit;
    holdNext      = enable & limitEn & (hitNow | (limHold & flags.aboveLow));
    satNext       = enable & limitEn & (satMode | hitNow);
    strobe.useSat = satNext;
    onNext        = enable & ~holdNext & flags.surfNeg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limHold <= 1'b0;
      satMode <= 1'b0;
      hsOn    <= 1'b0;
    end else begin
      limHold <= holdNext;
      satMode <= satNext;
      hsOn    <= onNext;
    end
  end

  assert_limit_forces_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && limitEn && flags.atLimit) |=> !hsOn);

  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!hsOn && !limHold && !satMode));

  assert_sat_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(satMode) |-> $past(!enable || !limitEn));

  assert_hold_needs_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(limHold) |-> $past(limitEn && flags.atLimit));

  assert_hold_keeps_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    limHold |-> !hsOn);

endmodule

// File: rtl/ssc_controller.sv
module ssc_controller
  import ssc_pkg::*;
#(
  parameter int ERR_W      = 10,
  parameter int IC_W       = 12,
  parameter int SLOPE_W    = 12,
  parameter int SLOPE_FRAC = 4,
  parameter int GAMMA_W    = 5,
  parameter int GAMMA_FRAC = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic                      limitEn,
  input  logic signed [ERR_W-1:0]   errIn,
  input  logic signed [IC_W-1:0]    icIn,
  input  logic signed [SLOPE_W-1:0] baseSlope,
  input  logic        [GAMMA_W-1:0] gammaIn,
  input  logic signed [SLOPE_W-1:0] satSlope,
  input  logic signed [IC_W-1:0]    icMax,
  input  logic        [IC_W-1:0]    icHyst,
  output logic                      hsOn
);

  ctrlStrobeT strobe;
  cmpFlagsT   flags;

  ssc_datapath #(
    .ERR_W(ERR_W), .IC_W(IC_W), .SLOPE_W(SLOPE_W), .SLOPE_FRAC(SLOPE_FRAC),
    .GAMMA_W(GAMMA_W), .GAMMA_FRAC(GAMMA_FRAC)
  ) datapath_i (
    .clk(clk), .rstN(rstN),
    .errIn(errIn), .icIn(icIn), .baseSlope(baseSlope), .gammaIn(gammaIn),
    .satSlope(satSlope), .icMax(icMax), .icHyst(icHyst),
    .strobe(strobe), .flags(flags)
  );

  ssc_control control_i (
    .clk(clk), .rstN(rstN), .enable(enable), .limitEn(limitEn),
    .flags(flags), .strobe(strobe), .hsOn(hsOn)
  );

endmodule

// File: tb/ssc_controller_tb_top.sv
module ssc_controller_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, limitEn = 1'b0;
  logic signed [9:0]  errIn = '0;
  logic signed [11:0] icIn = '0, baseSlope = '0, satSlope = '0, icMax = '0;
  logic        [4:0]  gammaIn = '0;
  logic        [11:0] icHyst = '0;
  logic hsOn;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ssc_controller dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .limitEn(limitEn),
    .errIn(errIn), .icIn(icIn), .baseSlope(baseSlope), .gammaIn(gammaIn),
    .satSlope(satSlope), .icMax(icMax), .icHyst(icHyst), .hsOn(hsOn)
  );

  typedef struct packed {
    logic signed [9:0]  e;
    logic signed [11:0] ic;
    logic signed [11:0] base;
    logic        [4:0]  g;
    logic        [1:0]  req;   // 1 = R1, 2 = R2, 3 = R3
    logic               exp;
  } vecT;

  // Expected results worked out from S = e + (g/8)(base/16) ic
  localparam vecT VEC [11] = '{
    '{e: -10'sd10,  ic:  12'sd0,    base:  12'sd16,   g: 5'd8,  req: 2'd1, exp: 1'b1},
    '{e:  10'sd10,  ic:  12'sd0,    base:  12'sd16,   g: 5'd8,  req: 2'd1, exp: 1'b0},
    '{e:  10'sd0,   ic:  12'sd0,    base:  12'sd16,   g: 5'd8,  req: 2'd1, exp: 1'b0},
    '{e: -10'sd20,  ic:  12'sd5,    base:  12'sd64,   g: 5'd8,  req: 2'd1, exp: 1'b0},
    '{e: -10'sd20,  ic:  12'sd5,    base:  12'sd64,   g: 5'd4,  req: 2'd1, exp: 1'b1},
    '{e:  10'sd30,  ic: -12'sd3,    base:  12'sd48,   g: 5'd31, req: 2'd2, exp: 1'b1},
    '{e:  10'sd30,  ic: -12'sd3,    base:  12'sd48,   g: 5'd24, req: 2'd2, exp: 1'b0},
    '{e:  10'sd5,   ic: -12'sd2000, base:  12'sd2047, g: 5'd0,  req: 2'd2, exp: 1'b0},
    '{e: -10'sd512, ic: -12'sd2048, base: -12'sd2048, g: 5'd31, req: 2'd3, exp: 1'b0},
    '{e:  10'sd511, ic: -12'sd2048, base:  12'sd2047, g: 5'd31, req: 2'd3, exp: 1'b1},
    '{e: -10'sd3,   ic:  12'sd2,    base: -12'sd32,   g: 5'd8,  req: 2'd1, exp: 1'b1}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic signed [9:0] e, input logic signed [11:0] ic);
    @(negedge clk);
    errIn = e;
    icIn  = ic;
  endtask

  task automatic stepCheck(input string tag, input logic signed [9:0] e,
                           input logic signed [11:0] ic, input logic exp);
    drive(e, ic);
    @(posedge clk);
    #1;
    check(tag, hsOn, exp);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", hsOn, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    enable = 1'b1;

    // Table walk: linear surface, limit mode off
    foreach (VEC[i]) begin
      string tag;
      tag = (VEC[i].req == 2'd1) ? "R1" : (VEC[i].req == 2'd2) ? "R2" : "R3";
      @(negedge clk);
      baseSlope = VEC[i].base;
      gammaIn   = VEC[i].g;
      stepCheck($sformatf("%s vector %0d", tag, i), VEC[i].e, VEC[i].ic, VEC[i].exp);
    end

    // R4: latency -- previous result held until the next edge
    baseSlope = 12'sd16; gammaIn = 5'd8;            // slope 1.0
    stepCheck("R4 setup", -10'sd50, 12'sd0, 1'b1);
    drive(10'sd50, 12'sd0);
    #1;
    check("R4 before edge", hsOn, 1'b1);
    @(posedge clk); #1;
    check("R4 after edge", hsOn, 1'b0);

    // R5: disabled output is off
    @(negedge clk); enable = 1'b0;
    stepCheck("R5 disabled", -10'sd100, 12'sd0, 1'b0);
    @(negedge clk); enable = 1'b1;

    // R9: limit mode off ignores the ceiling
    icMax = 12'sd100; icHyst = 12'd20; satSlope = 12'sd8;   // sat slope 0.5
    stepCheck("R9 ceiling ignored", -10'sd300, 12'sd150, 1'b1);

    // Current-limit sequence
    @(negedge clk); limitEn = 1'b1;
    stepCheck("R6 below ceiling", -10'sd100, 12'sd50, 1'b1);
    stepCheck("R6 hit overrides surface", -10'sd300, 12'sd100, 1'b0);
    stepCheck("R7 held inside band", -10'sd300, 12'sd85, 1'b0);
    stepCheck("R7 held at band edge", -10'sd300, 12'sd80, 1'b0);
    stepCheck("R7 released below band", -10'sd300, 12'sd79, 1'b1);
    // linear: -60+79 = 19 -> off ; saturated: -60+39.5 -> on
    stepCheck("R8 saturated surface used", -10'sd60, 12'sd79, 1'b1);

    // R9: leaving limit mode returns to the linear surface
    @(negedge clk); limitEn = 1'b0;
    stepCheck("R9 linear after mode off", -10'sd60, 12'sd79, 1'b0);
    @(negedge clk); limitEn = 1'b1;
    stepCheck("R8 saturated state cleared", -10'sd60, 12'sd79, 1'b0);

    // R5: disable clears hold and saturated state
    stepCheck("R6 second hit", -10'sd300, 12'sd120, 1'b0);
    @(negedge clk); enable = 1'b0;
    stepCheck("R5 off while disabled", -10'sd300, 12'sd85, 1'b0);
    @(negedge clk); enable = 1'b1;
    stepCheck("R5 hold cleared by disable", -10'sd300, 12'sd85, 1'b1);
    // linear: -60+79 = 19 -> off proves the saturated state is gone
    stepCheck("R5 sat cleared by disable", -10'sd60, 12'sd79, 1'b0);

    // R10: asynchronous reset mid-run
    stepCheck("R10 pre-reset", -10'sd100, 12'sd0, 1'b1);
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R10 async reset", hsOn, 1'b0);

    done = 1;
    finishRun();
  end

endmodule